// File: doc/BRIEF.md
# Width-Adapting External Bus Master

This block turns one internal access request into a sequence of external bus data cycles. A request names a byte address, a four-bit byte mask, a direction, a burst of one to four 32-bit words and, for writes, the data of every word in the burst. A per-request width code says whether the target region is 32, 16 or 8 bits wide. The block then drives a word-aligned address, four byte-enable pins, an outgoing data bus, a read/write line and an address strobe. Each data cycle lasts until the bus returns ready. When the final data cycle of the request ends, the block gives a one-cycle done pulse with all read words packed together.

The meaning of the four byte-enable pins depends on the region width. On a 32-bit region they are plain lane enables. On a 16-bit region they carry byte-high-enable, address bit 1 and byte-low-enable. On an 8-bit region the two low pins carry address bits 1 and 0. A 32-bit word aimed at a narrow region is split into halfword or byte data cycles. Halves or bytes whose mask bits are clear are skipped. All byte-enable pins are active-high, and unused pins are held at 0.

The request side is a valid/ready stream. `req_ready` is high exactly when no request is in progress, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. Holding `req_valid` while the block is busy has no effect. The done pulse cannot be stalled, so whoever consumes the result must take `rsp_data` in the cycle `rsp_done` is high. `MAX_WORDS` must be a power of two no smaller than 2.

Top module: `ebm_top`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress, including the done cycle. A request is taken only on a clock edge with `req_valid` and `req_ready` both high. Requests offered while busy leave the bus cycles unchanged.
- R2: `bus_ads` is high for exactly one clock per request: the first clock after acceptance, which is also the first clock the new address is driven.
- R3: `bus_rd` is 1 for reads (`req_write`=0) and 0 for writes. It changes only in a clock where `bus_ads` is high, and it holds its value for the whole request.
- R4: For word w of a burst (w from 0), `bus_addr` bits above bit 3 equal the request address bits above bit 3. `bus_addr[3:2]` equals (request address bits 3:2 + w) mod 4. This holds for every data cycle of that word.
- R5: A 32-bit region (`req_width` 2'b10, and also 2'b11) gives one data cycle per word. In that cycle `bus_be` equals the mask, and on writes `bus_dout` is the whole word.
- R6: A 16-bit region (`req_width` 2'b01) handles the low half before the high half. `bus_be` is {mask bit of the half's upper byte, 0, half index, mask bit of the half's lower byte}. On writes, the selected halfword is on `bus_dout[15:0]` and bits 31:16 are 0.
- R7: An 8-bit region (`req_width` 2'b00) handles bytes in ascending order. `bus_be` is {0, 0, byte index}. On writes, the selected byte is on `bus_dout[7:0]` and bits 31:8 are 0.
- R8: On narrow regions, a half with both mask bits clear or a byte with its mask bit clear gets no data cycle. A request mask of 0 is handled as 4'hF.
- R9: A data cycle ends at a clock edge where `bus_rdy` is high and `bus_ads` or the block is active. Until then, address, byte enables and write data hold.
- R10: One clock after the edge that ends the last data cycle, `rsp_done` is high for one clock. `rsp_data` then holds word w at bits [32w+31:32w]. Each byte of a read word is the bus data returned for its lane (16-bit: `bus_din[15:0]`, 8-bit: `bus_din[7:0]`) when its mask bit is set, and 0 otherwise. After a write all bytes are 0.
- R11: During reads `bus_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the first word |
| req_mask | input | 4 | Byte mask applied to every word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Burst length in words minus one |
| req_width | input | 2 | Region width: 00 = 8, 01 = 16, 1x = 32 bit |
| req_wdata | input | MAX_WORDS*32 | Write words, word w at bits 32w upward |
| bus_addr | output | ADDR_W-2 | Word address (address bits ADDR_W-1 down to 2) |
| bus_be | output | 4 | Byte-enable pins, meaning set by region width |
| bus_dout | output | 32 | Outgoing bus data |
| bus_din | input | 32 | Incoming bus data |
| bus_rd | output | 1 | 1 = read access, 0 = write access |
| bus_ads | output | 1 | Address strobe, first clock of a request |
| bus_rdy | input | 1 | Ends the current data cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | MAX_WORDS*32 | Packed read words, valid with rsp_done |

## Verification
The bench keeps the defaults ADDR_W = 32 and MAX_WORDS = 4. With these values a four-word burst started at an address whose bits 3:2 are nonzero runs its word index past 3 and back to 0, so the wrap of the low address bits is exercised. The full four-word packed response also carries bytes from every lane position of every word in each region width. Ready is held low for several clocks in some requests and also dropped at random, and junk requests are offered while the block is busy.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  typedef enum logic [1:0] {
    BW8  = 2'b00,
    BW16 = 2'b01,
    BW32 = 2'b10
  } bw_e;

  function automatic bw_e norm_bw(input logic [1:0] code);
    if (code == 2'b00)      return BW8;
    else if (code == 2'b01) return BW16;
    else                    return BW32;
  endfunction

  // Lowest selected transfer unit at or above 'from'; 4 means none left.
  function automatic logic [2:0] pick_unit(input bw_e bw, input logic [3:0] m,
                                           input logic [2:0] from);
    logic [2:0] r;
    logic       hit;
    r = 3'd4;
    for (int u = 3; u >= 0; u--) begin
      case (bw)
        BW8:     hit = m[u];
        BW16:    hit = (u == 0) ? (|m[1:0]) : ((u == 1) ? (|m[3:2]) : 1'b0);
        default: hit = (u == 0);
      endcase
      if (hit && (3'(u) >= from)) r = 3'(u);
    end
    return r;
  endfunction

endpackage

// File: rtl/ebm_lane_map.sv
module ebm_lane_map
  import ebm_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  bw_e              bw,
  input  logic [LANES-1:0] mask,
  input  logic [1:0]       unit,
  input  logic             write,
  input  logic [DW-1:0]    wword,
  input  logic [DW-1:0]    din,
  output logic [LANES-1:0] be,
  output logic [DW-1:0]    dout,
  output logic [DW-1:0]    cap_data,
  output logic [LANES-1:0] cap_keep
);

  logic [LANES-1:0] lanes;

  always_comb begin
    be       = '0;
    dout     = '0;
    cap_data = '0;
    lanes    = '0;
    case (bw)
      BW8: begin
        be = {2'b00, unit};
        if (write) dout[7:0] = wword[8*unit +: 8];
        cap_data = {LANES{din[7:0]}};
        lanes    = LANES'(1) << unit;
      end
      BW16: begin
        if (unit[0]) begin
          be    = {mask[3], 1'b0, 1'b1, mask[2]};
          lanes = 4'b1100;
          if (write) dout[15:0] = wword[31:16];
        end else begin
          be    = {mask[1], 1'b0, 1'b0, mask[0]};
          lanes = 4'b0011;
          if (write) dout[15:0] = wword[15:0];
        end
        cap_data = {(LANES/2){din[15:0]}};
      end
      default: begin
        be = mask;
        if (write) dout = wword;
        cap_data = din;
        lanes    = '1;
      end
    endcase
    cap_keep = lanes & mask;
  end

endmodule

// File: rtl/ebm_rd_pack.sv
module ebm_rd_pack #(
  parameter int MAX_WORDS = 4,
  parameter int LEN_W = $clog2(MAX_WORDS),
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [LEN_W-1:0]        wr_idx,
  input  logic [LANES-1:0]        keep,
  input  logic [DW-1:0]           data,
  output logic [MAX_WORDS*DW-1:0] packed_words
);

  logic [DW-1:0] words_q [MAX_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int w = 0; w < MAX_WORDS; w++) words_q[w] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < LANES; b++)
        if (keep[b]) words_q[wr_idx][8*b +: 8] <= data[8*b +: 8];
    end
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_out
    assign packed_words[DW*w +: DW] = words_q[w];
  end

endmodule

// File: rtl/ebm_seq.sv
module ebm_seq
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_WORDS = 4,
  parameter int LEN_W = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_mask,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_width,
  input  logic              bus_rdy,
  output logic              busy,
  output logic              ads,
  output logic              rd_flag,
  output logic [ADDR_W-1:2] word_addr,
  output bw_e               cur_bw,
  output logic [3:0]        cur_mask,
  output logic [LEN_W-1:0]  cur_word,
  output logic [1:0]        cur_unit,
  output logic              accept,
  output logic              beat_fire,
  output logic              done
);

  logic              busy_q, first_q, rd_q, done_q;
  bw_e               bw_q;
  logic [3:0]        mask_q;
  logic [ADDR_W-1:2] base_q;
  logic [LEN_W-1:0]  len_q, word_q;
  logic [1:0]        unit_q;

  logic [3:0] mask_in;
  bw_e        bw_in;
  logic [2:0] unit_in, unit_next, unit_restart;
  logic [LEN_W-1:0] addr_lo;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign beat_fire = busy_q && bus_rdy;

  always_comb begin
    mask_in      = (req_mask == 4'h0) ? 4'hF : req_mask;
    bw_in        = norm_bw(req_width);
    unit_in      = pick_unit(bw_in, mask_in, 3'd0);
    unit_next    = pick_unit(bw_q, mask_q, {1'b0, unit_q} + 3'd1);
    unit_restart = pick_unit(bw_q, mask_q, 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      first_q <= 1'b0;
      rd_q <= 1'b0;
      done_q <= 1'b0;
      bw_q <= BW32;
      mask_q <= 4'h0;
      base_q <= '0;
      len_q <= '0;
      word_q <= '0;
      unit_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        first_q <= 1'b1;
        rd_q    <= !req_write;
        bw_q    <= bw_in;
        mask_q  <= mask_in;
        base_q  <= req_addr[ADDR_W-1:2];
        len_q   <= req_len;
        word_q  <= '0;
        unit_q  <= unit_in[1:0];
      end else if (busy_q) begin
        first_q <= 1'b0;
        if (bus_rdy) begin
          if (!unit_next[2]) begin
            unit_q <= unit_next[1:0];
          end else if (word_q == len_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            word_q <= word_q + LEN_W'(1);
            unit_q <= unit_restart[1:0];
          end
        end
      end
    end
  end

  assign addr_lo   = base_q[LEN_W+1:2] + word_q;
  assign word_addr = {base_q[ADDR_W-1:LEN_W+2], addr_lo};
  assign busy      = busy_q;
  assign ads       = busy_q && first_q;
  assign rd_flag   = rd_q;
  assign cur_bw    = bw_q;
  assign cur_mask  = mask_q;
  assign cur_word  = word_q;
  assign cur_unit  = unit_q;
  assign done      = done_q;

  // R2: the strobe never lasts two clocks
  assert_ads_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ads |=> !ads);
  // R1: completion is reported only with the block idle again
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  // R10: completion follows an edge that ended a data cycle
  assert_done_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy && bus_rdy));

endmodule

// File: rtl/ebm_top.sv
module ebm_top
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_WORDS = 4,
  parameter int LEN_W = $clog2(MAX_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [3:0]              req_mask,
  input  logic                    req_write,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [1:0]              req_width,
  input  logic [MAX_WORDS*32-1:0] req_wdata,
  output logic [ADDR_W-1:2]       bus_addr,
  output logic [3:0]              bus_be,
  output logic [31:0]             bus_dout,
  input  logic [31:0]             bus_din,
  output logic                    bus_rd,
  output logic                    bus_ads,
  input  logic                    bus_rdy,
  output logic                    rsp_done,
  output logic [MAX_WORDS*32-1:0] rsp_data
);

  localparam int LANES = 4;
  localparam int DW = LANES * 8;
  localparam int PACK_W = MAX_WORDS * DW;

  logic              busy, ads, rd_flag, accept, beat_fire, done;
  logic [ADDR_W-1:2] word_addr;
  bw_e               cur_bw;
  logic [3:0]        cur_mask;
  logic [LEN_W-1:0]  cur_word;
  logic [1:0]        cur_unit;
  logic [PACK_W-1:0] wbuf_q, packed_words;
  logic [DW-1:0]     lane_dout, cap_data;
  logic [LANES-1:0]  lane_be, cap_keep;

  ebm_seq #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_mask(req_mask), .req_write(req_write), .req_len(req_len),
    .req_width(req_width), .bus_rdy(bus_rdy),
    .busy(busy), .ads(ads), .rd_flag(rd_flag), .word_addr(word_addr),
    .cur_bw(cur_bw), .cur_mask(cur_mask), .cur_word(cur_word),
    .cur_unit(cur_unit), .accept(accept), .beat_fire(beat_fire), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      wbuf_q <= '0;
    else if (accept) wbuf_q <= req_wdata;
  end

  ebm_lane_map #(.LANES(LANES)) u_map (
    .bw(cur_bw), .mask(cur_mask), .unit(cur_unit), .write(!rd_flag),
    .wword(wbuf_q[DW*cur_word +: DW]), .din(bus_din),
    .be(lane_be), .dout(lane_dout), .cap_data(cap_data), .cap_keep(cap_keep)
  );

  ebm_rd_pack #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .wr_en(beat_fire && rd_flag), .wr_idx(cur_word),
    .keep(cap_keep), .data(cap_data), .packed_words(packed_words)
  );

  assign bus_addr = busy ? word_addr : '0;
  assign bus_be   = busy ? lane_be : '0;
  assign bus_dout = busy ? lane_dout : '0;
  assign bus_rd   = rd_flag;
  assign bus_ads  = ads;
  assign rsp_done = done;
  assign rsp_data = done ? packed_words : '0;

  // R3: direction changes only together with the strobe
  assert_rd_with_ads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_rd) |-> bus_ads);
  // R4: upper address bits fixed for the whole request
  assert_addr_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ads) |-> $stable(bus_addr[ADDR_W-1:LEN_W+2]));
  // R9: without ready the data cycle holds its pins
  assert_hold_on_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_rdy) |=> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_dout)));
  // R6: 16-bit region leaves pin 2 and the upper lanes quiet
  assert_narrow16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_bw == BW16) |-> (!bus_be[2] && bus_dout[31:16] == 16'h0));
  // R7: 8-bit region leaves pins 3:2 and lanes above 7 quiet
  assert_narrow8_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_bw == BW8) |-> (bus_be[3:2] == 2'b00 && bus_dout[31:8] == 24'h0));
  // R11: reads drive no data
  assert_read_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rd) |-> (bus_dout == 32'h0));

endmodule

// File: tb/tb_ebm_top.sv
module tb_ebm_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 44;
  localparam int WATCHDOG = 60000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [3:0]   req_mask = '0;
  logic         req_write = 1'b0;
  logic [1:0]   req_len = '0;
  logic [1:0]   req_width = '0;
  logic [127:0] req_wdata = '0;
  logic [31:2]  bus_addr;
  logic [3:0]   bus_be;
  logic [31:0]  bus_dout;
  logic [31:0]  bus_din = '0;
  logic         bus_rd, bus_ads;
  logic         bus_rdy = 1'b0;
  logic         rsp_done;
  logic [127:0] rsp_data;

  always #(CLK_PERIOD/2) clk = !clk;

  ebm_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_write(req_write),
    .req_len(req_len), .req_width(req_width), .req_wdata(req_wdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_rd(bus_rd), .bus_ads(bus_ads), .bus_rdy(bus_rdy),
    .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;

  // request list
  logic [31:0]  r_addr [NREQ];
  logic [3:0]   r_mask [NREQ];
  logic         r_wr   [NREQ];
  logic [1:0]   r_len  [NREQ];
  logic [1:0]   r_w    [NREQ];
  logic [127:0] r_data [NREQ];
  logic         r_junk [NREQ];
  int           r_hold [NREQ];

  // reference model state
  logic [29:0] q_addr [$];
  logic [3:0]  q_be [$];
  logic [31:0] q_dout [$];
  int          q_word [$];
  int          q_byte0 [$];
  int          q_nb [$];
  logic [7:0]  exp_b [16];
  logic        exp_first = 1'b0;
  logic        pend_done = 1'b0;
  logic [3:0]  cur_mask = '0;
  logic        cur_wr = 1'b0;
  int          cur_bits = 32;
  int          hold = 0;
  logic        junk = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_req(input int i, input logic [31:0] a, input logic [3:0] m,
                         input logic wr, input logic [1:0] len, input logic [1:0] w,
                         input logic jk, input int hd);
    r_addr[i] = a; r_mask[i] = m; r_wr[i] = wr; r_len[i] = len; r_w[i] = w;
    r_data[i] = {$urandom, $urandom, $urandom, $urandom};
    r_junk[i] = jk; r_hold[i] = hd;
  endtask

  task automatic push(input logic [29:0] a, input logic [3:0] be, input logic [31:0] d,
                      input int wd, input int b0, input int nb);
    q_addr.push_back(a); q_be.push_back(be); q_dout.push_back(d);
    q_word.push_back(wd); q_byte0.push_back(b0); q_nb.push_back(nb);
  endtask

  task automatic build(input int i);
    logic [3:0]  m;
    logic [31:0] wd;
    logic [29:0] a;
    m = (r_mask[i] == 4'h0) ? 4'hF : r_mask[i];
    cur_mask = m;
    cur_wr = r_wr[i];
    cur_bits = (r_w[i] == 2'b00) ? 8 : ((r_w[i] == 2'b01) ? 16 : 32);
    for (int k = 0; k < 16; k++) exp_b[k] = 8'h00;
    for (int w = 0; w <= int'(r_len[i]); w++) begin
      a = {r_addr[i][31:4], 2'(r_addr[i][3:2] + 2'(w))};
      wd = r_data[i][32*w +: 32];
      if (cur_bits == 32) begin
        push(a, m, cur_wr ? wd : 32'h0, w, 0, 4);
      end else if (cur_bits == 16) begin
        for (int h = 0; h < 2; h++)
          if (((m >> (2*h)) & 4'h3) != 0)
            push(a, {m[2*h+1], 1'b0, 1'(h), m[2*h]},
                 cur_wr ? ((wd >> (16*h)) & 32'hFFFF) : 32'h0, w, 2*h, 2);
      end else begin
        for (int b = 0; b < 4; b++)
          if (m[b])
            push(a, {2'b00, 2'(b)}, cur_wr ? ((wd >> (8*b)) & 32'hFF) : 32'h0, w, b, 1);
      end
    end
    exp_first = 1'b1;
  endtask

  function automatic string wtag();
    if (cur_bits == 8) return "R7";
    if (cur_bits == 16) return "R6";
    return "R5";
  endfunction

  initial begin
    int idx;
    int cyc;
    logic idle;
    logic [127:0] exp_pack;
    logic [31:0] din_now;

    // directed requests
    set_req(0, 32'h0000_0100, 4'hF, 1'b0, 2'd0, 2'b10, 1'b0, 0);   // R5 read
    set_req(1, 32'h0000_1008, 4'h5, 1'b1, 2'd3, 2'b10, 1'b1, 0);   // R4 wrap, R1 junk
    set_req(2, 32'h0000_2000, 4'hF, 1'b1, 2'd1, 2'b01, 1'b0, 6);   // R6 write, R9 stall
    set_req(3, 32'h0000_3004, 4'h2, 1'b0, 2'd0, 2'b01, 1'b0, 0);   // R8 high half skipped
    set_req(4, 32'h0000_300C, 4'hC, 1'b0, 2'd1, 2'b01, 1'b1, 0);   // R8 low half skipped
    set_req(5, 32'h0000_4000, 4'hF, 1'b1, 2'd0, 2'b00, 1'b0, 0);   // R7 write
    set_req(6, 32'h0000_4004, 4'hA, 1'b0, 2'd2, 2'b00, 1'b0, 5);   // R7 R8 read
    set_req(7, 32'h0000_5000, 4'h0, 1'b0, 2'd0, 2'b00, 1'b0, 0);   // R8 zero mask
    set_req(8, 32'h0000_6008, 4'h9, 1'b0, 2'd1, 2'b11, 1'b1, 0);   // R5 code 11
    set_req(9, 32'h0000_700C, 4'h6, 1'b1, 2'd3, 2'b01, 1'b0, 0);   // R4 R6 burst
    for (int i = 10; i < NREQ; i++)
      set_req(i, $urandom, 4'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
              1'($urandom), (($urandom % 4) == 0) ? 3 : 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    idx = 0;
    cyc = 0;
    // reset state checks
    @(negedge clk);
    chk("R1", "ready after reset", 128'(req_ready), 128'(1));
    chk("R2", "ads after reset", 128'(bus_ads), 128'(0));
    chk("R10", "done after reset", 128'(rsp_done), 128'(0));

    while (idx < NREQ || q_addr.size() != 0 || pend_done) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog R9 actual=%0d expected<=%0d", cyc, WATCHDOG);
        break;
      end
      idle = (q_addr.size() == 0);
      // compare every clock
      chk("R1", "req_ready", 128'(req_ready), 128'(idle));
      chk("R2", "ads", 128'(bus_ads), 128'(exp_first && !idle));
      chk("R10", "done", 128'(rsp_done), 128'(pend_done));
      if (pend_done) begin
        for (int k = 0; k < 16; k++) exp_pack[8*k +: 8] = exp_b[k];
        chk("R10", "rsp_data", rsp_data, exp_pack);
        pend_done = 1'b0;
      end
      if (!idle) begin
        chk("R3", "bus_rd", 128'(bus_rd), 128'(!cur_wr));
        chk("R4", "bus_addr", 128'(bus_addr), 128'(q_addr[0]));
        chk({wtag(), " R8 R9"}, "bus_be", 128'(bus_be), 128'(q_be[0]));
        chk(cur_wr ? {wtag(), " R9"} : "R11", "bus_dout", 128'(bus_dout), 128'(q_dout[0]));
        exp_first = 1'b0;
      end
      // ready and read data for this clock
      din_now = $urandom;
      bus_din = din_now;
      if (hold > 0) begin
        bus_rdy = 1'b0;
        hold--;
      end else begin
        bus_rdy = (($urandom % 3) != 0);
      end
      if (!idle && bus_rdy) begin
        if (!cur_wr)
          for (int j = 0; j < q_nb[0]; j++) begin
            int k;
            k = q_byte0[0] + j;
            if (cur_mask[k]) exp_b[4*q_word[0] + k] = din_now[8*j +: 8];
          end
        void'(q_addr.pop_front()); void'(q_be.pop_front()); void'(q_dout.pop_front());
        void'(q_word.pop_front()); void'(q_byte0.pop_front()); void'(q_nb.pop_front());
        if (q_addr.size() == 0) pend_done = 1'b1;
      end
      // request side
      if (idle && idx < NREQ) begin
        req_valid = 1'b1;
        req_addr = r_addr[idx]; req_mask = r_mask[idx]; req_write = r_wr[idx];
        req_len = r_len[idx]; req_width = r_w[idx]; req_wdata = r_data[idx];
        build(idx);
        junk = r_junk[idx];
        hold = r_hold[idx];
        idx++;
      end else if (!idle && junk && q_addr.size() != 0) begin
        // R1: offered while busy, must be ignored
        req_valid = 1'b1;
        req_addr = $urandom; req_mask = 4'($urandom); req_write = 1'($urandom);
        req_len = 2'($urandom); req_width = 2'($urandom);
        req_wdata = {$urandom, $urandom, $urandom, $urandom};
      end else begin
        req_valid = 1'b0;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule